// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the machine-level control and status registers of a small single-hart 32-bit processor. It also decides when control flow leaves the normal instruction stream. Each cycle, decode presents at most one instruction through `insn_valid` and `insn_pc`. That instruction may carry:

- a CSR access (address, operation, source value and a flag saying the source is zero);
- exception strobes for an illegal encoding, an environment call or a breakpoint;
- a return-from-trap strobe.

The unit answers in the same cycle with:

- the CSR read value;
- a trap flag;
- a redirect flag with the next program counter.

All state updates land on the following clock edge.

The interrupt sources are a timer line, a software line and a vector of external request lines. The external lines feed a small controller with a mask register at CSR 0x330 and a read-only pending view at CSR 0x360. When any line is both pending and unmasked, a single machine external interrupt is raised. Interrupts are only taken at an instruction boundary (`insn_valid` high). They are held off while the global enable in the status register is clear. When an interrupt is taken, the instruction presented in that cycle is abandoned and its PC is saved as the return address.

Top module: `mcsr_trap_unit`

## Requirements
- R1: After reset the status CSR 0x300 reads 0x00001800. The trap vector CSR 0x305 reads the parameter `TVEC_RESET`. CSRs 0x304, 0x330, 0x340, 0x341, 0x342 and 0x343 read zero.
- R2: A CSR access with `csr_op` 1 writes the source value, with 2 sets the bits that are one in the source, and with 3 clears them. With 2 or 3 and `csr_src_zero` high, no write happens. `csr_rdata` shows the value held before the access. The implemented addresses are 0x300, 0x304, 0x305, 0x330, 0x340, 0x341, 0x342, 0x343 and 0x360.
- R3: Only bits 3 (global enable) and 7 (previous enable) of CSR 0x300 are writable, and bits 12:11 always read 1. CSR 0x304 keeps only bits 3, 7 and 11. CSRs 0x305 and 0x341 always read zero in bits 1:0.
- R4: CSR 0x330 is a read-write external mask. CSR 0x360 reads the live `irq_ext` lines, and writes to it change nothing.
- R5: An instruction with `ex_illegal`, or a CSR access to an unimplemented address, traps with cause 2, and `insn_word` is stored in CSR 0x343.
- R6: An environment call traps with cause 11 and a breakpoint with cause 3. Both store 0 in CSR 0x343.
- R7: On any trap, `trap_taken` and `pc_redirect` rise in the same cycle and `next_pc` is CSR 0x305 with bits 1:0 cleared. On the next edge, CSR 0x341 takes `insn_pc` with bits 1:0 cleared, bit 7 of 0x300 takes bit 3, and bit 3 is cleared.
- R8: `mret` on a non-trapping instruction raises `pc_redirect` with `next_pc` equal to CSR 0x341. On the next edge, bit 3 of 0x300 takes bit 7, and bit 7 becomes 1.
- R9: An external interrupt is requested when any bit of `irq_ext` AND CSR 0x330 is set. It is taken only with bit 3 of 0x300 and bit 11 of 0x304 set, and uses cause 0x8000000B.
- R10: Exceptions are ranked illegal, then breakpoint, then environment call, and all of them rank above interrupts. Among interrupts, external ranks first, then software (cause 0x80000003, enable bit 3), then timer (cause 0x80000007, enable bit 7). No trap is taken while `insn_valid` is low, and no interrupt is taken while bit 3 of 0x300 is clear.
- R11: An instruction that traps performs neither its CSR write nor its return-from-trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | An instruction is at the boundary this cycle |
| insn_pc | input | 32 | PC of that instruction |
| insn_word | input | 32 | Instruction encoding, stored on illegal traps |
| csr_valid | input | 1 | Instruction accesses a CSR |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 0 none, 1 write, 2 set, 3 clear |
| csr_wdata | input | 32 | Register value or zero-extended immediate |
| csr_src_zero | input | 1 | Source register index or immediate is zero |
| csr_rdata | output | 32 | Value of the addressed CSR before the access |
| ex_illegal | input | 1 | Decode found an illegal encoding |
| ex_ecall | input | 1 | Environment call |
| ex_ebreak | input | 1 | Breakpoint |
| mret | input | 1 | Return from trap |
| irq_timer | input | 1 | Timer interrupt request |
| irq_soft | input | 1 | Software interrupt request |
| irq_ext | input | EXT_LINES | External interrupt request lines |
| trap_taken | output | 1 | The current instruction traps |
| pc_redirect | output | 1 | Fetch must continue at `next_pc` |
| next_pc | output | 32 | Trap vector or saved return address |

## Verification
The bench builds the unit with `EXT_LINES` at 32 and the default reset vector. This makes the lowest and highest external lines, and a mask that is set only at both ends, reachable for directed cases. The random phase lets all three interrupt sources land in the same cycle as exceptions, CSR writes to the enables and returns. This tests the priority order and the abandoning of a trapping instruction's side effects against a bench model of the CSR file.

// File: rtl/mcsr_pkg.sv
// Shared constants for the machine CSR and trap unit: operation codes,
// CSR addresses, bit positions of enable fields and trap cause values.
package mcsr_pkg;
    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_ENABLE  = 12'h304;
    localparam logic [11:0] A_VECTOR  = 12'h305;
    localparam logic [11:0] A_XMASK   = 12'h330;
    localparam logic [11:0] A_SCRATCH = 12'h340;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_TVAL    = 12'h343;
    localparam logic [11:0] A_XPEND   = 12'h360;

    localparam int B_GIE  = 3;
    localparam int B_PGIE = 7;
    localparam int B_SW   = 3;
    localparam int B_TIM  = 7;
    localparam int B_EXT  = 11;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    localparam logic [XLEN-1:0] C_ILLEGAL = 32'd2;
    localparam logic [XLEN-1:0] C_BREAK   = 32'd3;
    localparam logic [XLEN-1:0] C_ECALL   = 32'd11;
    localparam logic [XLEN-1:0] C_IRQ_SW  = 32'h8000_0003;
    localparam logic [XLEN-1:0] C_IRQ_TIM = 32'h8000_0007;
    localparam logic [XLEN-1:0] C_IRQ_EXT = 32'h8000_000B;
endpackage

// File: rtl/mcsr_rmw.sv
// Read-modify-write stage of a CSR access.
// Computes the value a CSR would hold after the access, and whether a
// write happens at all. Set and clear with a zero source perform no write.
// Assumes the caller gates the result with its own commit condition.
module mcsr_rmw
    import mcsr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] src_val,
    input  logic [1:0]   op,
    input  logic         src_zero,
    output logic [W-1:0] new_val,
    output logic         do_write
);
    csr_op_e op_e;
    assign op_e = csr_op_e'(op);

    // Select the combined value and the write permission for the operation.
    always_comb begin
        new_val  = old_val;
        do_write = 1'b0;
        unique case (op_e)
            OP_WRITE: begin
                new_val  = src_val;
                do_write = 1'b1;
            end
            OP_SET: begin
                new_val  = old_val | src_val;
                do_write = !src_zero;
            end
            OP_CLEAR: begin
                new_val  = old_val & ~src_val;
                do_write = !src_zero;
            end
            default: begin
                new_val  = old_val;
                do_write = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mcsr_ext_irq.sv
// External interrupt controller.
// Holds the mask register and exposes the request lines as a read-only
// pending view. Raises one request when any pending line is unmasked.
// Assumes the lines are already synchronous to clk and level-sensitive.
module mcsr_ext_irq #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [LINES-1:0] mask_wdata,
    input  logic [LINES-1:0] lines,
    output logic [LINES-1:0] mask_q,
    output logic [LINES-1:0] pend,
    output logic             req
);
    // Mask register, cleared at reset, written by committed CSR accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    assign pend = lines;
    assign req  = |(pend & mask_q);
endmodule

// File: rtl/mcsr_trap_pick.sv
// Trap arbitration.
// Ranks the synchronous exceptions of the current instruction above all
// interrupts, then picks external, software and timer in that order.
// Outputs the winning cause code.
// Assumes the caller qualifies `take` with the instruction-boundary signal.
module mcsr_trap_pick
    import mcsr_pkg::*;
(
    input  logic            bad_insn,
    input  logic            brk,
    input  logic            ecall,
    input  logic            glob_en,
    input  logic            en_sw,
    input  logic            en_tim,
    input  logic            en_ext,
    input  logic            req_sw,
    input  logic            req_tim,
    input  logic            req_ext,
    output logic            take,
    output logic            is_exc,
    output logic [XLEN-1:0] cause
);
    logic ok_ext, ok_sw, ok_tim;
    assign ok_ext = glob_en && en_ext && req_ext;
    assign ok_sw  = glob_en && en_sw  && req_sw;
    assign ok_tim = glob_en && en_tim && req_tim;

    // Fixed-priority choice of the trap cause.
    always_comb begin
        take   = 1'b1;
        is_exc = 1'b1;
        cause  = C_ILLEGAL;
        if (bad_insn) begin
            cause = C_ILLEGAL;
        end else if (brk) begin
            cause = C_BREAK;
        end else if (ecall) begin
            cause = C_ECALL;
        end else begin
            is_exc = 1'b0;
            if (ok_ext) begin
                cause = C_IRQ_EXT;
            end else if (ok_sw) begin
                cause = C_IRQ_SW;
            end else if (ok_tim) begin
                cause = C_IRQ_TIM;
            end else begin
                take  = 1'b0;
                cause = '0;
            end
        end
    end
endmodule

// File: rtl/mcsr_trap_unit.sv
// Machine-mode CSR file and trap unit.
// Serves CSR reads in the same cycle and commits writes on the next edge.
// Decides whether the instruction at the boundary traps, and drives the
// redirect PC for traps and returns.
// Assumes one instruction per cycle at most, and that decode never raises
// a CSR access together with a return on the same instruction.
module mcsr_trap_unit
    import mcsr_pkg::*;
#(
    parameter int          EXT_LINES  = 32,
    parameter logic [31:0] TVEC_RESET = 32'h0000_0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 insn_valid,
    input  logic [31:0]          insn_pc,
    input  logic [31:0]          insn_word,
    input  logic                 csr_valid,
    input  logic [11:0]          csr_addr,
    input  logic [1:0]           csr_op,
    input  logic [31:0]          csr_wdata,
    input  logic                 csr_src_zero,
    output logic [31:0]          csr_rdata,
    input  logic                 ex_illegal,
    input  logic                 ex_ecall,
    input  logic                 ex_ebreak,
    input  logic                 mret,
    input  logic                 irq_timer,
    input  logic                 irq_soft,
    input  logic [EXT_LINES-1:0] irq_ext,
    output logic                 trap_taken,
    output logic                 pc_redirect,
    output logic [31:0]          next_pc
);
    localparam int EXT_PAD = XLEN - EXT_LINES;

    // Architectural state
    logic                  gie_q, pgie_q;
    logic                  en_sw_q, en_tim_q, en_ext_q;
    logic [XLEN-1:2]       vec_q;
    logic [XLEN-1:2]       epc_q;
    logic [XLEN-1:0]       scratch_q, cause_q, tval_q;
    logic [EXT_LINES-1:0]  xmask_q, xpend;
    logic                  ext_req;

    logic [XLEN-1:0] xmask_rd, xpend_rd, status_rd, enable_rd;
    logic [XLEN-1:0] old_val, new_val;
    logic            addr_hit, rmw_write, csr_bad;
    logic            pick_take, pick_exc;
    logic [XLEN-1:0] pick_cause;
    logic            wr_commit, ret_commit;

    // Zero-extend the external controller's registers to the CSR width.
    generate
        if (EXT_PAD > 0) begin : g_pad
            assign xmask_rd = {{EXT_PAD{1'b0}}, xmask_q};
            assign xpend_rd = {{EXT_PAD{1'b0}}, xpend};
        end else begin : g_full
            assign xmask_rd = xmask_q;
            assign xpend_rd = xpend;
        end
    endgenerate

    always_comb begin
        status_rd              = '0;
        status_rd[12:11]       = PRIV_MACHINE;
        status_rd[B_GIE]       = gie_q;
        status_rd[B_PGIE]      = pgie_q;
        enable_rd              = '0;
        enable_rd[B_SW]        = en_sw_q;
        enable_rd[B_TIM]       = en_tim_q;
        enable_rd[B_EXT]       = en_ext_q;
    end

    // Read multiplexer and address decode.
    always_comb begin
        addr_hit = 1'b1;
        unique case (csr_addr)
            A_STATUS:  old_val = status_rd;
            A_ENABLE:  old_val = enable_rd;
            A_VECTOR:  old_val = {vec_q, 2'b00};
            A_XMASK:   old_val = xmask_rd;
            A_SCRATCH: old_val = scratch_q;
            A_EPC:     old_val = {epc_q, 2'b00};
            A_CAUSE:   old_val = cause_q;
            A_TVAL:    old_val = tval_q;
            A_XPEND:   old_val = xpend_rd;
            default: begin
                old_val  = '0;
                addr_hit = 1'b0;
            end
        endcase
    end

    assign csr_rdata = old_val;
    assign csr_bad   = csr_valid && !addr_hit;

    mcsr_rmw #(.W(XLEN)) u_rmw (
        .old_val  (old_val),
        .src_val  (csr_wdata),
        .op       (csr_op),
        .src_zero (csr_src_zero),
        .new_val  (new_val),
        .do_write (rmw_write)
    );

    mcsr_ext_irq #(.LINES(EXT_LINES)) u_xirq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (wr_commit && (csr_addr == A_XMASK)),
        .mask_wdata (new_val[EXT_LINES-1:0]),
        .lines      (irq_ext),
        .mask_q     (xmask_q),
        .pend       (xpend),
        .req        (ext_req)
    );

    mcsr_trap_pick u_pick (
        .bad_insn (ex_illegal || csr_bad),
        .brk      (ex_ebreak),
        .ecall    (ex_ecall),
        .glob_en  (gie_q),
        .en_sw    (en_sw_q),
        .en_tim   (en_tim_q),
        .en_ext   (en_ext_q),
        .req_sw   (irq_soft),
        .req_tim  (irq_timer),
        .req_ext  (ext_req),
        .take     (pick_take),
        .is_exc   (pick_exc),
        .cause    (pick_cause)
    );

    assign trap_taken  = insn_valid && pick_take;
    assign wr_commit   = insn_valid && csr_valid && addr_hit && rmw_write && !trap_taken;
    assign ret_commit  = insn_valid && mret && !trap_taken;
    assign pc_redirect = trap_taken || ret_commit;
    assign next_pc     = trap_taken ? {vec_q, 2'b00} : {epc_q, 2'b00};

    // Status enables: trap entry stacks, CSR writes load, return unstacks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q  <= 1'b0;
            pgie_q <= 1'b0;
        end else if (trap_taken) begin
            pgie_q <= gie_q;
            gie_q  <= 1'b0;
        end else if (wr_commit && (csr_addr == A_STATUS)) begin
            gie_q  <= new_val[B_GIE];
            pgie_q <= new_val[B_PGIE];
        end else if (ret_commit) begin
            gie_q  <= pgie_q;
            pgie_q <= 1'b1;
        end
    end

    // Software-only configuration registers: enables, vector, scratch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_sw_q   <= 1'b0;
            en_tim_q  <= 1'b0;
            en_ext_q  <= 1'b0;
            vec_q     <= TVEC_RESET[XLEN-1:2];
            scratch_q <= '0;
        end else if (wr_commit) begin
            if (csr_addr == A_ENABLE) begin
                en_sw_q  <= new_val[B_SW];
                en_tim_q <= new_val[B_TIM];
                en_ext_q <= new_val[B_EXT];
            end
            if (csr_addr == A_VECTOR)  vec_q     <= new_val[XLEN-1:2];
            if (csr_addr == A_SCRATCH) scratch_q <= new_val;
        end
    end

    // Trap record registers: loaded on trap entry or by CSR writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
        end else if (trap_taken) begin
            epc_q   <= insn_pc[XLEN-1:2];
            cause_q <= pick_cause;
            tval_q  <= (pick_exc && (pick_cause == C_ILLEGAL)) ? insn_word : '0;
        end else if (wr_commit) begin
            if (csr_addr == A_EPC)   epc_q   <= new_val[XLEN-1:2];
            if (csr_addr == A_CAUSE) cause_q <= new_val;
            if (csr_addr == A_TVAL)  tval_q  <= new_val;
        end
    end
endmodule

// File: rtl/mcsr_trap_chk.sv
// Assertion checker for the machine CSR and trap unit, bound to the top.
// Relates trap entry, return and cause recording to the input strobes.
module mcsr_trap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_valid,
    input logic [31:0] insn_pc,
    input logic        ex_illegal,
    input logic        ex_ecall,
    input logic        ex_ebreak,
    input logic        csr_bad,
    input logic        trap_taken,
    input logic        pc_redirect,
    input logic        gie,
    input logic        pgie,
    input logic [31:2] epc,
    input logic [31:0] cause
);
    // R7
    epc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (epc == $past(insn_pc[31:2])));

    // R7
    enable_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> (!gie && (pgie == $past(gie))));

    // R8
    return_unstack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_redirect && !trap_taken) |=> ((gie == $past(pgie)) && pgie));

    // R5
    illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && (ex_illegal || csr_bad)) |=> (cause == 32'd2));

    // R6
    ecall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && ex_ecall && !ex_illegal && !ex_ebreak && !csr_bad)
        |=> (cause == 32'd11));

    // R10
    exc_always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && (ex_illegal || ex_ecall || ex_ebreak || csr_bad)) |-> trap_taken);

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && !ex_illegal && !ex_ecall && !ex_ebreak && !csr_bad) |-> gie);

    // R10
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |-> !pc_redirect);
endmodule

bind mcsr_trap_unit mcsr_trap_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_valid  (insn_valid),
    .insn_pc     (insn_pc),
    .ex_illegal  (ex_illegal),
    .ex_ecall    (ex_ecall),
    .ex_ebreak   (ex_ebreak),
    .csr_bad     (csr_bad),
    .trap_taken  (trap_taken),
    .pc_redirect (pc_redirect),
    .gie         (gie_q),
    .pgie        (pgie_q),
    .epc         (epc_q),
    .cause       (cause_q)
);

// File: tb/sim_mcsr_trap_unit.sv
// Self-checking bench: directed corner cases followed by seeded random
// instruction streams, compared against a model of the CSR file.
module sim_mcsr_trap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int EXT_LINES  = 32;
    localparam int RAND_CYCLES = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        insn_valid, csr_valid, csr_src_zero;
    logic        ex_illegal, ex_ecall, ex_ebreak, mret, irq_timer, irq_soft;
    logic [31:0] insn_pc, insn_word, csr_wdata;
    logic [11:0] csr_addr;
    logic [1:0]  csr_op;
    logic [EXT_LINES-1:0] irq_ext;
    logic [31:0] csr_rdata, next_pc;
    logic        trap_taken, pc_redirect;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    bit          m_gie, m_pgie;
    logic [31:0] m_ie, m_vec, m_scr, m_epc, m_cause, m_tval, m_xmask;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcsr_trap_unit #(.EXT_LINES(EXT_LINES), .TVEC_RESET(32'h0000_0100)) u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_pc(insn_pc),
        .insn_word(insn_word), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_src_zero(csr_src_zero),
        .csr_rdata(csr_rdata), .ex_illegal(ex_illegal), .ex_ecall(ex_ecall),
        .ex_ebreak(ex_ebreak), .mret(mret), .irq_timer(irq_timer),
        .irq_soft(irq_soft), .irq_ext(irq_ext), .trap_taken(trap_taken),
        .pc_redirect(pc_redirect), .next_pc(next_pc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic bit known(input logic [11:0] a);
        return a == 12'h300 || a == 12'h304 || a == 12'h305 || a == 12'h330 ||
               a == 12'h340 || a == 12'h341 || a == 12'h342 || a == 12'h343 ||
               a == 12'h360;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h300: return 32'h1800 | (32'(m_gie) << 3) | (32'(m_pgie) << 7);
            12'h304: return m_ie;
            12'h305: return m_vec;
            12'h330: return m_xmask;
            12'h340: return m_scr;
            12'h341: return m_epc;
            12'h342: return m_cause;
            12'h343: return m_tval;
            12'h360: return irq_ext;
            default: return 32'h0;
        endcase
    endfunction

    function automatic void m_write(input logic [11:0] a, input logic [31:0] v);
        case (a)
            12'h300: begin m_gie = v[3]; m_pgie = v[7]; end
            12'h304: m_ie = v & 32'h888;
            12'h305: m_vec = v & ~32'h3;
            12'h330: m_xmask = v;
            12'h340: m_scr = v;
            12'h341: m_epc = v & ~32'h3;
            12'h342: m_cause = v;
            12'h343: m_tval = v;
            default: ;
        endcase
    endfunction

    function automatic string tag_for(input logic [11:0] a);
        if (a == 12'h330 || a == 12'h360) return "R4 csr read";
        if (a == 12'h300 || a == 12'h304 || a == 12'h305 || a == 12'h341) return "R3 csr read";
        return "R2 csr read";
    endfunction

    task automatic idle();
        insn_valid = 0; csr_valid = 0; csr_src_zero = 0; ex_illegal = 0;
        ex_ecall = 0; ex_ebreak = 0; mret = 0; irq_timer = 0; irq_soft = 0;
        insn_pc = 0; insn_word = 0; csr_wdata = 0; csr_addr = 0; csr_op = 0;
        irq_ext = '0;
    endtask

    // Check outputs against the model, advance the model, move to next negedge.
    task automatic tick();
        bit bad, exc, ereq, irq, trap, redir, we;
        logic [31:0] cause, nv, old;
        #1;
        bad   = csr_valid && !known(csr_addr);
        exc   = ex_illegal || bad || ex_ebreak || ex_ecall;
        ereq  = |(irq_ext & m_xmask);
        irq   = m_gie && ((ereq && m_ie[11]) || (irq_soft && m_ie[3]) || (irq_timer && m_ie[7]));
        trap  = insn_valid && (exc || irq);
        redir = trap || (insn_valid && mret);
        check("R10 trap_taken", 32'(trap_taken), 32'(trap));
        check("R8 pc_redirect", 32'(pc_redirect), 32'(redir));
        if (trap) check("R7 next_pc", next_pc, m_vec & ~32'h3);
        else if (redir) check("R8 next_pc", next_pc, m_epc);
        if (csr_valid && known(csr_addr)) check(tag_for(csr_addr), csr_rdata, m_read(csr_addr));
        if (trap) begin
            if (ex_illegal || bad) cause = 32'd2;
            else if (ex_ebreak) cause = 32'd3;
            else if (ex_ecall) cause = 32'd11;
            else if (ereq && m_ie[11]) cause = 32'h8000_000B;
            else if (irq_soft && m_ie[3]) cause = 32'h8000_0003;
            else cause = 32'h8000_0007;
            m_epc   = insn_pc & ~32'h3;
            m_cause = cause;
            m_tval  = (ex_illegal || bad) ? insn_word : 32'h0;
            m_pgie  = m_gie;
            m_gie   = 0;
        end else if (insn_valid) begin
            if (csr_valid) begin
                old = m_read(csr_addr);
                we  = 0;
                nv  = old;
                case (csr_op)
                    2'd1: begin nv = csr_wdata; we = 1; end
                    2'd2: begin nv = old | csr_wdata; we = !csr_src_zero; end
                    2'd3: begin nv = old & ~csr_wdata; we = !csr_src_zero; end
                    default: ;
                endcase
                if (we) m_write(csr_addr, nv);
            end
            if (mret) begin m_gie = m_pgie; m_pgie = 1; end
        end
        @(negedge clk);
        idle();
    endtask

    task automatic csr_do(input logic [11:0] a, input logic [1:0] op,
                          input logic [31:0] wd, input bit sz);
        insn_valid = 1; csr_valid = 1; csr_addr = a; csr_op = op;
        csr_wdata = wd; csr_src_zero = sz;
        tick();
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] exp, input string tag);
        csr_valid = 1; csr_addr = a; csr_op = 0;
        #1;
        check(tag, csr_rdata, exp);
        tick();
    endtask

    task automatic ret_now();
        insn_valid = 1; mret = 1;
        tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] pool [11];
        pool = '{12'h300, 12'h304, 12'h305, 12'h330, 12'h340, 12'h341,
                 12'h342, 12'h343, 12'h360, 12'h344, 12'hC00};
        void'($urandom(32'd4242));
        idle();
        rst_n = 0;
        m_gie = 0; m_pgie = 0; m_ie = 0; m_vec = 32'h100; m_scr = 0;
        m_epc = 0; m_cause = 0; m_tval = 0; m_xmask = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd_exp(12'h300, 32'h0000_1800, "R1 status");
        rd_exp(12'h304, 32'h0, "R1 enable");
        rd_exp(12'h305, 32'h100, "R1 vector");
        rd_exp(12'h330, 32'h0, "R1 xmask");
        rd_exp(12'h340, 32'h0, "R1 scratch");
        rd_exp(12'h341, 32'h0, "R1 epc");
        rd_exp(12'h342, 32'h0, "R1 cause");
        rd_exp(12'h343, 32'h0, "R1 tval");

        // R3 field masks
        csr_do(12'h305, 2'd1, 32'h0000_2003, 0);
        rd_exp(12'h305, 32'h0000_2000, "R3 vector low bits");
        csr_do(12'h304, 2'd1, 32'hFFFF_FFFF, 0);
        rd_exp(12'h304, 32'h0000_0888, "R3 enable mask");
        csr_do(12'h300, 2'd1, 32'hFFFF_FFFF, 0);
        rd_exp(12'h300, 32'h0000_1888, "R3 status mask");
        csr_do(12'h300, 2'd1, 32'h0, 0);
        rd_exp(12'h300, 32'h0000_1800, "R3 status cleared");

        // R2 set / clear / zero-source
        csr_do(12'h340, 2'd2, 32'h0000_00F0, 0);
        csr_do(12'h340, 2'd3, 32'h0000_0030, 0);
        rd_exp(12'h340, 32'h0000_00C0, "R2 set then clear");
        csr_do(12'h340, 2'd2, 32'h0000_00FF, 1);
        rd_exp(12'h340, 32'h0000_00C0, "R2 zero source no write");

        // R4 pending is read-only and live, mask is read-write
        irq_ext = 32'h5;
        csr_do(12'h360, 2'd1, 32'hFFFF_FFFF, 0);
        irq_ext = 32'h5;
        rd_exp(12'h360, 32'h0000_0005, "R4 pending ignores write");
        csr_do(12'h330, 2'd1, 32'h8000_0001, 0);
        rd_exp(12'h330, 32'h8000_0001, "R4 mask");

        // R6 / R7 environment call
        insn_valid = 1; ex_ecall = 1; insn_pc = 32'h404;
        #1;
        check("R6 ecall trap", 32'(trap_taken), 32'h1);
        check("R7 vector target", next_pc, 32'h2000);
        tick();
        rd_exp(12'h342, 32'd11, "R6 ecall cause");
        rd_exp(12'h341, 32'h404, "R7 epc");
        rd_exp(12'h343, 32'h0, "R6 ecall tval");

        // R9 / R10 external wins over software and timer
        csr_do(12'h300, 2'd1, 32'h8, 0);
        insn_valid = 1; insn_pc = 32'h502; irq_ext = 32'h8000_0000;
        irq_soft = 1; irq_timer = 1;
        #1;
        check("R9 external trap", 32'(trap_taken), 32'h1);
        tick();
        rd_exp(12'h342, 32'h8000_000B, "R10 external first");
        rd_exp(12'h341, 32'h500, "R7 epc aligned");
        rd_exp(12'h300, 32'h0000_1880, "R7 enable stacked");

        // R8 return
        insn_valid = 1; mret = 1;
        #1;
        check("R8 redirect", 32'(pc_redirect), 32'h1);
        check("R8 no trap", 32'(trap_taken), 32'h0);
        check("R8 return target", next_pc, 32'h500);
        tick();
        rd_exp(12'h300, 32'h0000_1888, "R8 enable restored");

        insn_valid = 1; irq_soft = 1; irq_timer = 1; tick();
        rd_exp(12'h342, 32'h8000_0003, "R10 software over timer");
        ret_now();
        insn_valid = 1; irq_timer = 1; tick();
        rd_exp(12'h342, 32'h8000_0007, "R10 timer");
        ret_now();

        // R9 masked line does not interrupt
        insn_valid = 1; irq_ext = 32'h2;
        #1;
        check("R9 masked line", 32'(trap_taken), 32'h0);
        tick();

        // R10 exception over interrupt
        insn_valid = 1; ex_ecall = 1; irq_ext = 32'h1; tick();
        rd_exp(12'h342, 32'd11, "R10 exception over irq");
        ret_now();

        // R5 / R10 illegal over breakpoint
        insn_valid = 1; ex_illegal = 1; ex_ebreak = 1; insn_word = 32'hDEAD_BEEF; tick();
        rd_exp(12'h342, 32'd2, "R5 illegal cause");
        rd_exp(12'h343, 32'hDEAD_BEEF, "R5 illegal tval");
        ret_now();
        insn_valid = 1; ex_ebreak = 1; insn_word = 32'h0010_0073; tick();
        rd_exp(12'h342, 32'd3, "R6 break cause");
        rd_exp(12'h343, 32'h0, "R6 break tval");
        ret_now();

        // R5 unimplemented CSR
        insn_word = 32'h3445_1073;
        insn_valid = 1; csr_valid = 1; csr_addr = 12'h344; csr_op = 2'd1;
        csr_wdata = 32'h1234; insn_word = 32'h3445_1073;
        #1;
        check("R5 bad csr trap", 32'(trap_taken), 32'h1);
        tick();
        rd_exp(12'h342, 32'd2, "R5 bad csr cause");
        rd_exp(12'h343, 32'h3445_1073, "R5 bad csr tval");
        ret_now();

        // R11 trapping instruction has no side effects
        insn_valid = 1; ex_ecall = 1; csr_valid = 1; csr_addr = 12'h340;
        csr_op = 2'd1; csr_wdata = 32'h55; tick();
        rd_exp(12'h340, 32'h0000_00C0, "R11 csr write dropped");
        ret_now();
        insn_valid = 1; ex_ecall = 1; mret = 1; tick();
        rd_exp(12'h300, 32'h0000_1880, "R11 return dropped");
        ret_now();

        // R10 global enable and boundary gating
        csr_do(12'h300, 2'd1, 32'h0, 0);
        insn_valid = 1; irq_soft = 1;
        #1;
        check("R10 global enable off", 32'(trap_taken), 32'h0);
        tick();
        csr_do(12'h300, 2'd1, 32'h8, 0);
        insn_valid = 0; irq_soft = 1;
        #1;
        check("R10 no boundary", 32'(pc_redirect), 32'h0);
        tick();

        // Random phase
        for (int i = 0; i < RAND_CYCLES; i++) begin
            insn_valid = ($urandom % 10) != 0;
            insn_pc    = $urandom;
            insn_word  = $urandom;
            if ($urandom % 2) begin
                csr_valid = 1;
                csr_addr  = pool[$urandom % 11];
                csr_op    = 2'($urandom);
                csr_wdata = ($urandom % 3 == 0) ? 32'h888 : $urandom;
                csr_src_zero = ($urandom % 6) == 0;
            end else begin
                mret = ($urandom % 6) == 0;
            end
            ex_illegal = ($urandom % 20) == 0;
            ex_ecall   = ($urandom % 20) == 0;
            ex_ebreak  = ($urandom % 20) == 0;
            irq_timer  = ($urandom % 5) == 0;
            irq_soft   = ($urandom % 5) == 0;
            irq_ext    = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule